// File: doc/BRIEF.md
# Synapse Event Trigger and Latch Configuration

This block decides, for every address-event it receives, which cells of a row-by-column synapse array emit a stimulation pulse. Events arrive one at a time over a four-phase request/acknowledge channel. The same channel carries three kinds of traffic: spikes aimed at one cell, spikes broadcast to one column, and commands that write one of three per-cell configuration bits. The three bits are a monitor select, a broadcast enable and a recurrent enable.

A separate input carries spikes from the local neurons, one line per column. A local spike on column j fires every cell in that column whose recurrent bit is set, so neurons can be wired to each other inside the array. Each cell's trigger is widened by its own pulse stretcher to a length set by a global input. The monitor bit selects one cell, and that cell's weight state is sent to a shared readout line.

Top module: `synapse_trigger`

## Requirements
- R1: After reset the acknowledge is low, every stimulation pulse is low, every configuration bit is cleared, and mon_active and mon_out are low.
- R2: The event word is {val, sel[1:0], row, col, kind[1:0]}, with kind in the lowest bits. When ev_req is sampled high while ev_ack is low, the event is accepted at that edge. At the same edge ev_ack rises and the event's effect is registered. ev_ack stays high while ev_req is high and falls at the first edge that samples ev_req low. A new event is only taken while ev_ack is low.
- R3: kind 0 (direct spike) fires only the cell whose row and column both match, whatever its configuration bits.
- R4: kind 1 (broadcast spike) fires, in parallel, every cell in the addressed column whose broadcast bit is set. The row field is ignored.
- R5: rec_spike[j] sampled high at an edge fires every cell in column j whose recurrent bit is set. The pulse is visible after that same edge.
- R6: kind 2 (write) stores val into the bit chosen by sel of cell (row, col): 0 monitor, 1 broadcast, 2 recurrent. sel 3 changes nothing. kind 3 is acknowledged and has no effect.
- R7: At most one monitor bit is set. Writing 1 to a cell's monitor bit clears all the others, and writing 0 clears only that cell. mon_active is high when a monitor bit is set, and mon_out then equals w_state of that cell (otherwise 0).
- R8: A trigger makes the cell's stim_pulse high for exactly stretch_len cycles, starting the cycle after the triggering edge. A length of 0 is treated as 1.
- R9: A trigger while a cell's pulse is active restarts that cell's count at the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_req | input | 1 | Event request |
| ev_data | input | EV_W | Event word {val, sel, row, col, kind} |
| ev_ack | output | 1 | Event acknowledge |
| rec_spike | input | COLS | Local neuron spikes, one per column |
| stretch_len | input | LEN_W | Global pulse length in cycles |
| w_state | input | ROWS*COLS | Weight state per cell, index row*COLS+col |
| stim_pulse | output | ROWS*COLS | Stretched stimulation pulse per cell |
| mon_active | output | 1 | A monitor bit is set |
| mon_out | output | 1 | Weight of the monitored cell |

## Verification
Every result of this block is due one edge after its cause:
- ev_ack rises, and a written bit or a started pulse becomes visible, after the edge that samples ev_req high.
- A recurrent pulse appears after the edge that samples rec_spike.
- A pulse then ends stretch_len edges after it was loaded.

The bench keeps a behavioural model whose registers advance on the same rising edge as the design. It compares ev_ack, every stimulation bit and the monitor outputs on the falling edge of every cycle, so each expected value is sampled half a cycle after the edge that produced it.

// File: rtl/st_pkg.sv
package st_pkg;

  typedef enum logic [1:0] {
    EVK_DIRECT = 2'd0,
    EVK_BCAST  = 2'd1,
    EVK_WRITE  = 2'd2,
    EVK_NOP    = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    LSEL_MON  = 2'd0,
    LSEL_BC   = 2'd1,
    LSEL_REC  = 2'd2,
    LSEL_NONE = 2'd3
  } latch_sel_e;

  // Flat cell index used across the array.
  function automatic int unsigned cell_of(int unsigned row, int unsigned col,
                                          int unsigned cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/st_handshake.sv
module st_handshake #(
  parameter int ROW_W = 2,
  parameter int COL_W = 2,
  localparam int EV_W = 2 + COL_W + ROW_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_req,
  input  logic [EV_W-1:0]       ev_data,
  output logic                  ev_ack,
  output logic                  accept,
  output st_pkg::ev_kind_e      kind,
  output logic [ROW_W-1:0]      row,
  output logic [COL_W-1:0]      col,
  output st_pkg::latch_sel_e    sel,
  output logic                  val
);
  logic busy;

  assign accept = ev_req && !busy;
  assign ev_ack = busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                busy <= 1'b0;
    else if (accept)           busy <= 1'b1;
    else if (busy && !ev_req)  busy <= 1'b0;
  end

  // Field decode of the event word.
  assign kind = st_pkg::ev_kind_e'(ev_data[1:0]);
  assign col  = ev_data[2 +: COL_W];
  assign row  = ev_data[2 + COL_W +: ROW_W];
  assign sel  = st_pkg::latch_sel_e'(ev_data[2 + COL_W + ROW_W +: 2]);
  assign val  = ev_data[EV_W-1];

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ack) |-> $past(ev_req));
  // R2
  ack_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && ev_req |=> ev_ack);
  // R2
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && !ev_req |=> !ev_ack);

endmodule

// File: rtl/st_config.sv
module st_config #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CELLS = ROWS * COLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ROW_W-1:0]    row,
  input  logic [COL_W-1:0]    col,
  input  st_pkg::latch_sel_e  sel,
  input  logic                val,
  output logic [CELLS-1:0]    mon_en,
  output logic [CELLS-1:0]    bc_en,
  output logic [CELLS-1:0]    rec_en
);
  import st_pkg::*;

  logic mon_claim;   // a write that makes one cell the only monitored cell
  assign mon_claim = wr_en && (sel == LSEL_MON) && val;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic hit;
      assign hit = wr_en && (row == ROW_W'(r)) && (col == COL_W'(c));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bc_en[IDX]  <= 1'b0;
          rec_en[IDX] <= 1'b0;
          mon_en[IDX] <= 1'b0;
        end else begin
          if (hit && sel == LSEL_BC)  bc_en[IDX]  <= val;
          if (hit && sel == LSEL_REC) rec_en[IDX] <= val;
          if (mon_claim)                    mon_en[IDX] <= hit;
          else if (hit && sel == LSEL_MON)  mon_en[IDX] <= 1'b0;
        end
      end
    end
  end

  // R7
  mon_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mon_en));
  // R6
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bc_en) && $stable(rec_en) && $stable(mon_en));

endmodule

// File: rtl/st_stretch.sv
module st_stretch #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt;

  // A zero length still gives a single-cycle pulse.
  function automatic logic [LEN_W-1:0] load_of(input logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= load_of(len);
    else if (cnt != '0)  cnt <= cnt - LEN_W'(1);
  end

  assign active = (cnt != '0);

  // R8
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active);
  // R8
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig && !active |=> !active);

endmodule

// File: rtl/synapse_trigger.sv
module synapse_trigger #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int LEN_W = 6,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int EV_W  = 2 + COL_W + ROW_W + 3,
  localparam int CELLS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_req,
  input  logic [EV_W-1:0]   ev_data,
  output logic              ev_ack,
  input  logic [COLS-1:0]   rec_spike,
  input  logic [LEN_W-1:0]  stretch_len,
  input  logic [CELLS-1:0]  w_state,
  output logic [CELLS-1:0]  stim_pulse,
  output logic              mon_active,
  output logic              mon_out
);
  import st_pkg::*;

  logic              accept;
  ev_kind_e          kind;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  latch_sel_e        sel;
  logic              val;

  st_handshake #(.ROW_W(ROW_W), .COL_W(COL_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_data(ev_data),
    .ev_ack(ev_ack), .accept(accept), .kind(kind), .row(row), .col(col),
    .sel(sel), .val(val)
  );

  // Named event strobes, one cycle each.
  logic is_direct, is_bcast, wr_en;
  assign is_direct = accept && (kind == EVK_DIRECT);
  assign is_bcast  = accept && (kind == EVK_BCAST);
  assign wr_en     = accept && (kind == EVK_WRITE);

  logic [CELLS-1:0] mon_en, bc_en, rec_en;

  st_config #(.ROWS(ROWS), .COLS(COLS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .row(row), .col(col),
    .sel(sel), .val(val), .mon_en(mon_en), .bc_en(bc_en), .rec_en(rec_en)
  );

  logic [CELLS-1:0] direct_hit, bcast_hit, rec_hit, trig;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;

      assign direct_hit[IDX] = is_direct && (row == ROW_W'(r)) && (col == COL_W'(c));
      assign bcast_hit[IDX]  = is_bcast && (col == COL_W'(c)) && bc_en[IDX];
      assign rec_hit[IDX]    = rec_spike[c] && rec_en[IDX];
      assign trig[IDX]       = direct_hit[IDX] | bcast_hit[IDX] | rec_hit[IDX];

      st_stretch #(.LEN_W(LEN_W)) u_str (
        .clk(clk), .rst_n(rst_n), .trig(trig[IDX]), .len(stretch_len),
        .active(stim_pulse[IDX])
      );

      // R3
      direct_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct_hit[IDX] |=> stim_pulse[IDX]);
      // R5
      rec_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_hit[IDX] |=> stim_pulse[IDX]);
    end
  end

  assign mon_active = |mon_en;
  assign mon_out    = |(mon_en & w_state);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !ev_ack && (stim_pulse == '0) && !mon_active);

endmodule

// File: tb/synapse_trigger_tb.sv
module synapse_trigger_tb;
  localparam int ROWS = 4, COLS = 4, LEN_W = 4, N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_req = 1'b0;
  logic [8:0] ev_data = '0;
  logic ev_ack;
  logic [3:0] rec_dir = '0, rec_rnd = '0;
  logic rec_rand = 1'b0;
  logic [3:0] rec_spike;
  logic [LEN_W-1:0] stretch_len = 4'd3;
  logic [N-1:0] w_state = 16'hA5C3;
  logic [N-1:0] stim_pulse;
  logic mon_active, mon_out;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  assign rec_spike = rec_rand ? rec_rnd : rec_dir;

  always #2 clk = ~clk;   // 250 MHz

  synapse_trigger #(.ROWS(ROWS), .COLS(COLS), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_data(ev_data), .ev_ack(ev_ack),
    .rec_spike(rec_spike), .stretch_len(stretch_len), .w_state(w_state),
    .stim_pulse(stim_pulse), .mon_active(mon_active), .mon_out(mon_out)
  );

  // Behavioural reference model
  int m_bc[N], m_rec[N], m_mon[N], m_cnt[N];
  bit m_ack;

  always @(posedge clk) begin
    int kind, col, row, sel, val, ln;
    bit acc, fire;
    if (!rst_n) begin
      m_ack = 0;
      for (int i = 0; i < N; i++) begin
        m_bc[i] = 0; m_rec[i] = 0; m_mon[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      kind = int'(ev_data) % 4;
      col  = (int'(ev_data) / 4) % 4;
      row  = (int'(ev_data) / 16) % 4;
      sel  = (int'(ev_data) / 64) % 4;
      val  = int'(ev_data) / 256;
      acc  = ev_req && !m_ack;
      ln   = (stretch_len == 0) ? 1 : int'(stretch_len);
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          int k;
          k = r * COLS + c;
          fire = 0;
          if (acc && kind == 0 && row == r && col == c) fire = 1;
          if (acc && kind == 1 && col == c && m_bc[k] != 0) fire = 1;
          if (rec_spike[c] && m_rec[k] != 0) fire = 1;
          if (fire) m_cnt[k] = ln;
          else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
        end
      if (acc && kind == 2) begin
        int k;
        k = row * COLS + col;
        if (sel == 0) begin
          if (val != 0) begin
            for (int i = 0; i < N; i++) m_mon[i] = 0;
            m_mon[k] = 1;
          end else m_mon[k] = 0;
        end else if (sel == 1) m_bc[k] = val;
        else if (sel == 2) m_rec[k] = val;
      end
      if (acc) m_ack = 1;
      else if (m_ack && !ev_req) m_ack = 0;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [N-1:0] exp_stim;
    bit exp_ma, exp_mo;
    if (!done) begin
      exp_ma = 0; exp_mo = 0;
      for (int i = 0; i < N; i++) begin
        exp_stim[i] = (m_cnt[i] > 0);
        if (m_mon[i] != 0) begin exp_ma = 1; exp_mo = exp_mo | w_state[i]; end
      end
      checks++;
      if (ev_ack !== m_ack || stim_pulse !== exp_stim ||
          mon_active !== exp_ma || mon_out !== exp_mo) begin
        fails++;
        $display("FAIL %s cycle %0d: ack=%b stim=%h ma=%b mo=%b expected ack=%b stim=%h ma=%b mo=%b",
                 cur_tag, cycles, ev_ack, stim_pulse, mon_active, mon_out,
                 m_ack, exp_stim, exp_ma, exp_mo);
      end
    end
  end

  always @(negedge clk) if (rec_rand) rec_rnd <= (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;

  function automatic logic [8:0] mk_ev(int kind, int row, int col, int sel, int val);
    return {1'(val), 2'(sel), 2'(row), 2'(col), 2'(kind)};
  endfunction

  task automatic send_ev(input logic [8:0] d);
    @(negedge clk);
    ev_data = d; ev_req = 1'b1;
    do @(negedge clk); while (!ev_ack);
    ev_req = 1'b0;
    do @(negedge clk); while (ev_ack);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rec(input logic [3:0] p);
    @(negedge clk); rec_dir = p;
    @(negedge clk); rec_dir = 4'h0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: explicit reset-state check
    checks++;
    if (ev_ack !== 1'b0 || stim_pulse !== '0 || mon_active !== 1'b0 || mon_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: ack=%b stim=%h ma=%b expected 0 0 0", ev_ack, stim_pulse, mon_active);
    end

    cur_tag = "R3"; stretch_len = 4'd3;
    send_ev(mk_ev(0, 2, 1, 0, 0));
    send_ev(mk_ev(0, 0, 3, 3, 1));
    idle(4);

    cur_tag = "R2";   // hold request long, ack must stay high
    @(negedge clk); ev_data = mk_ev(0, 3, 3, 0, 0); ev_req = 1'b1;
    idle(6); ev_req = 1'b0; idle(3);

    cur_tag = "R6";
    send_ev(mk_ev(2, 0, 1, 1, 1));
    send_ev(mk_ev(2, 3, 1, 1, 1));
    send_ev(mk_ev(2, 2, 2, 1, 1));
    send_ev(mk_ev(2, 1, 0, 2, 1));
    send_ev(mk_ev(2, 1, 2, 2, 1));
    send_ev(mk_ev(2, 3, 2, 2, 1));
    send_ev(mk_ev(2, 0, 0, 3, 1));   // sel 3: nothing
    send_ev(mk_ev(3, 1, 1, 1, 1));   // kind 3: nothing
    cur_tag = "R4";
    send_ev(mk_ev(1, 0, 1, 0, 0));
    send_ev(mk_ev(1, 3, 2, 0, 0));
    send_ev(mk_ev(1, 2, 0, 0, 0));   // column with no broadcast bits
    send_ev(mk_ev(1, 0, 3, 1, 1));   // sel 3 write had no effect
    idle(4);
    cur_tag = "R6";
    send_ev(mk_ev(2, 0, 1, 1, 0));   // clear one broadcast bit
    cur_tag = "R4";
    send_ev(mk_ev(1, 1, 1, 0, 0));
    idle(4);

    cur_tag = "R5";
    pulse_rec(4'b0100); idle(4);
    pulse_rec(4'b0101); idle(4);
    pulse_rec(4'b1010); idle(4);

    cur_tag = "R8";
    stretch_len = 4'd0; send_ev(mk_ev(0, 1, 1, 0, 0)); idle(3);
    stretch_len = 4'd15; send_ev(mk_ev(0, 1, 1, 0, 0)); idle(18);
    stretch_len = 4'd5;

    cur_tag = "R9";
    for (int i = 0; i < 4; i++) begin pulse_rec(4'b0001); idle(1); end
    idle(8);

    cur_tag = "R7";
    send_ev(mk_ev(2, 1, 1, 0, 1)); idle(2);
    w_state = 16'h0200; idle(2);
    send_ev(mk_ev(2, 2, 3, 0, 1)); idle(2);
    w_state = 16'h0800; idle(2);
    send_ev(mk_ev(2, 1, 1, 0, 0)); idle(2);   // clearing a non-selected cell
    send_ev(mk_ev(2, 2, 3, 0, 0)); idle(3);

    cur_tag = "mixed";
    rec_rand = 1'b1;
    for (int i = 0; i < 400; i++) begin
      stretch_len = 4'($urandom);
      w_state = 16'($urandom);
      send_ev(9'($urandom));
      idle($urandom % 3);
    end
    rec_rand = 1'b0;
    idle(20);
    finish_run();
  end

endmodule